// File: doc/BRIEF.md
# DMA Request Command Sequencer

This block works through one channel's queue of DMA request elements, one at a time. It decodes the control word of each request and then carries out the requested steps in a fixed order. First it waits for any fences to clear. Next comes at most one gating semaphore, then the optional data transfer, then any post-transfer semaphores, then an optional sized doorbell write. Last, if the request asks for one, it pushes a completion response. The data mover, address translation and the host bus sit outside the block. They are reached through simple handshakes: a semaphore request/grant pair, a transfer start pulse with a done strobe, a doorbell write strobe, and a response push that stalls while the response queue is full.

Each request carries the following:
- a 32-bit control word;
- a sequence ID, which the block ignores;
- two semaphore slots, each with an enable, a presync flag and an ID;
- a doorbell address and data word.

Two outstanding-transfer counts arrive from outside, one for each direction. The fences compare against these counts.

Top module: `dreq_seq`

## Requirements
- R1: While control bit 30 (to-device fence) is set and `todev_cnt` is non-zero, the request raises no semaphore request, no transfer start and no doorbell write. It proceeds once the count reaches zero.
- R2: While control bit 29 (from-device fence) is set and `fromdev_cnt` is non-zero, the request likewise stalls. It proceeds once that count reaches zero.
- R3: An enabled slot with its presync flag at 1 is granted before `xfer_start`. Enabled slots with presync 0 are served after `xfer_done`, in increasing slot order. `sem_req` stays high until `sem_grant`.
- R4: If more than one enabled slot has presync set, the request performs no semaphore, transfer or doorbell step, and its response carries status 2.
- R5: The doorbell length is control bits 1:0 and the doorbell enable is control bit 2. Code 0 gives `db_strb` 4'b1111, code 1 gives 4'b0011 and code 2 gives 4'b0001. Address and data are passed through unchanged.
- R6: Code 3 is reserved. With the doorbell enabled, code 3 causes no doorbell write and gives response status 1.
- R7: The transfer is enabled by control bit 3. Without it no `xfer_start` occurs, so a request may consist of semaphores and a doorbell only. `xfer_start` is a single-cycle pulse.
- R8: Control bit 4 requests a completion response. When set, exactly one `resp_push` is made at the end of the request with status 0 on success. It holds with a stable status while `resp_full` is high. When bit 4 is clear, no response is pushed.
- R9: The sequence ID has no effect on any output.
- R10: Requests are handled strictly in order. `req_ready` is low from acceptance until the request has pushed its response or retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request element offered |
| req_ready | output | 1 | Sequencer idle and taking a request |
| req_ctrl | input | 32 | Control word (fences, completion, transfer, doorbell enable and length) |
| req_seq_id | input | SIDW | Sequence ID, ignored |
| req_sem_en | input | NSEM | Per-slot semaphore enable |
| req_sem_pre | input | NSEM | Per-slot presync flag (1 gates the transfer) |
| req_sem_id | input | NSEM*SEMW | Per-slot semaphore IDs, slot 0 in the low bits |
| req_db_addr | input | DBAW | Doorbell address |
| req_db_data | input | 32 | Doorbell data |
| todev_cnt | input | CW | Outstanding to-device transfers |
| fromdev_cnt | input | CW | Outstanding from-device transfers |
| sem_req | output | 1 | Semaphore operation requested |
| sem_id | output | SEMW | ID of the requested semaphore |
| sem_grant | input | 1 | Semaphore operation completed |
| xfer_start | output | 1 | Start the data transfer (pulse) |
| xfer_done | input | 1 | Transfer finished |
| db_we | output | 1 | Doorbell write strobe |
| db_addr | output | DBAW | Doorbell address |
| db_data | output | 32 | Doorbell data |
| db_strb | output | 4 | Doorbell byte enables |
| resp_push | output | 1 | Push a response entry |
| resp_status | output | 8 | Response status, 0 is success |
| resp_full | input | 1 | Response queue full, hold the push |

## Verification
Two actions can meet in the same cycle: a finished request pushing its response, and the next request waiting to be accepted. The bench raises `resp_full` while a completed request sits at its response step and keeps the next request offered. It then judges that `req_ready` stays low and that no event of the next request appears until the push is released. A fence also meets counter activity: the bench holds an outstanding count non-zero with the next request already accepted. It confirms that no scoreboard event appears during that stall, and that the expected sequence follows once the count drops to zero.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    localparam int CTRL_W        = 32;
    localparam int BIT_FENCE_TO  = 30;
    localparam int BIT_FENCE_FR  = 29;
    localparam int BIT_CMPL      = 4;
    localparam int BIT_XFER      = 3;
    localparam int BIT_DB_EN     = 2;

    localparam logic [7:0] STAT_OK       = 8'd0;
    localparam logic [7:0] STAT_BAD_LEN  = 8'd1;
    localparam logic [7:0] STAT_MULTIPRE = 8'd2;

    typedef enum logic [1:0] {
        DBL_W32  = 2'd0,
        DBL_W16  = 2'd1,
        DBL_W8   = 2'd2,
        DBL_RSVD = 2'd3
    } db_len_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FENCE, S_PRE, S_XSTART, S_XWAIT, S_POST, S_DB, S_RESP
    } seq_st_e;

    typedef struct packed {
        logic       fence_to;
        logic       fence_fr;
        logic       cmpl;
        logic       xfer;
        logic       db_go;
        logic       multi_pre;
        logic [3:0] strb;
        logic [7:0] status;
    } req_flags_t;

    function automatic logic [3:0] len_to_strb(db_len_e l);
        case (l)
            DBL_W32: return 4'b1111;
            DBL_W16: return 4'b0011;
            DBL_W8:  return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/dreq_decode.sv
module dreq_decode
    import dreq_pkg::*;
#(
    parameter int NSEM = 2
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [NSEM-1:0]   sem_en,
    input  logic [NSEM-1:0]   sem_pre,
    output req_flags_t        flags,
    output logic [NSEM-1:0]   pre_mask,
    output logic [NSEM-1:0]   post_mask
);
    localparam int CNTW = $clog2(NSEM + 1);

    logic [NSEM-1:0] pre_all;
    logic [CNTW-1:0] pre_cnt;
    logic            multi;
    logic            db_en;
    db_len_e         len;
    logic            ctrl_unused;

    assign ctrl_unused = ^{ctrl[31], ctrl[28:5]};
    assign pre_all     = sem_en & sem_pre;
    assign db_en       = ctrl[BIT_DB_EN];
    assign len         = db_len_e'(ctrl[1:0]);

    always_comb begin
        pre_cnt = '0;
        for (int i = 0; i < NSEM; i++) pre_cnt = pre_cnt + CNTW'(pre_all[i]);
    end

    assign multi = (pre_cnt > CNTW'(1));

    always_comb begin
        flags           = '0;
        flags.fence_to  = ctrl[BIT_FENCE_TO];
        flags.fence_fr  = ctrl[BIT_FENCE_FR];
        flags.cmpl      = ctrl[BIT_CMPL];
        flags.multi_pre = multi;
        flags.xfer      = ctrl[BIT_XFER] && !multi;
        flags.db_go     = db_en && (len != DBL_RSVD) && !multi;
        flags.strb      = len_to_strb(len);
        if (multi)
            flags.status = STAT_MULTIPRE;
        else if (db_en && len == DBL_RSVD)
            flags.status = STAT_BAD_LEN;
        else
            flags.status = STAT_OK;
    end

    assign pre_mask  = multi ? '0 : pre_all;
    assign post_mask = multi ? '0 : (sem_en & ~sem_pre);

endmodule

// File: rtl/dreq_sem_pick.sv
module dreq_sem_pick #(
    parameter int NSEM = 2,
    parameter int SEMW = 8,
    localparam int IW  = (NSEM > 1) ? $clog2(NSEM) : 1
) (
    input  logic [NSEM-1:0]      mask,
    input  logic [NSEM*SEMW-1:0] id_flat,
    output logic                 any,
    output logic [IW-1:0]        idx,
    output logic [SEMW-1:0]      id
);
    logic [SEMW-1:0] ids [NSEM];

    for (genvar g = 0; g < NSEM; g++) begin : g_unpack
        assign ids[g] = id_flat[g*SEMW +: SEMW];
    end

    always_comb begin
        idx = '0;
        for (int i = NSEM - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end

    assign any = |mask;
    assign id  = ids[idx];

endmodule

// File: rtl/dreq_ctrl.sv
module dreq_ctrl
    import dreq_pkg::*;
#(
    parameter int NSEM = 2,
    parameter int SEMW = 8,
    parameter int DBAW = 16,
    parameter int CW   = 4,
    localparam int IW  = (NSEM > 1) ? $clog2(NSEM) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  req_flags_t           flags_in,
    input  logic [NSEM-1:0]      pre_in,
    input  logic [NSEM-1:0]      post_in,
    input  logic [NSEM*SEMW-1:0] ids_in,
    input  logic [DBAW-1:0]      dba_in,
    input  logic [31:0]          dbd_in,
    input  logic [CW-1:0]        todev_cnt,
    input  logic [CW-1:0]        fromdev_cnt,
    output logic [NSEM-1:0]      sel_mask,
    output logic [NSEM*SEMW-1:0] ids_q,
    input  logic                 pick_any,
    input  logic [IW-1:0]        pick_idx,
    output logic                 sem_req,
    input  logic                 sem_grant,
    output logic                 xfer_start,
    input  logic                 xfer_done,
    output logic                 db_we,
    output logic [DBAW-1:0]      db_addr,
    output logic [31:0]          db_data,
    output logic [3:0]           db_strb,
    output logic                 resp_push,
    output logic [7:0]           resp_status,
    input  logic                 resp_full
);
    seq_st_e         st_q;
    req_flags_t      flags_q;
    logic [NSEM-1:0] pre_q, post_q;
    logic            blocked;

    assign blocked = (flags_q.fence_to && todev_cnt != '0) ||
                     (flags_q.fence_fr && fromdev_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            flags_q <= '0;
            pre_q   <= '0;
            post_q  <= '0;
            ids_q   <= '0;
            db_addr <= '0;
            db_data <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (req_valid) begin
                    flags_q <= flags_in;
                    pre_q   <= pre_in;
                    post_q  <= post_in;
                    ids_q   <= ids_in;
                    db_addr <= dba_in;
                    db_data <= dbd_in;
                    st_q    <= S_FENCE;
                end
                S_FENCE: if (!blocked) begin
                    if (flags_q.multi_pre)  st_q <= S_RESP;
                    else if (|pre_q)        st_q <= S_PRE;
                    else if (flags_q.xfer)  st_q <= S_XSTART;
                    else                    st_q <= S_POST;
                end
                S_PRE: if (sem_grant) begin
                    pre_q[pick_idx] <= 1'b0;
                    st_q <= flags_q.xfer ? S_XSTART : S_POST;
                end
                S_XSTART: st_q <= S_XWAIT;
                S_XWAIT:  if (xfer_done) st_q <= S_POST;
                S_POST: begin
                    if (!pick_any)      st_q <= S_DB;
                    else if (sem_grant) post_q[pick_idx] <= 1'b0;
                end
                S_DB:   st_q <= S_RESP;
                S_RESP: if (!flags_q.cmpl || !resp_full) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign sel_mask    = (st_q == S_PRE) ? pre_q : post_q;
    assign req_ready   = (st_q == S_IDLE);
    assign sem_req     = (st_q == S_PRE) || (st_q == S_POST && pick_any);
    assign xfer_start  = (st_q == S_XSTART);
    assign db_we       = (st_q == S_DB) && flags_q.db_go;
    assign db_strb     = flags_q.strb;
    assign resp_push   = (st_q == S_RESP) && flags_q.cmpl;
    assign resp_status = flags_q.status;

    AST_FENCE_TO_STALL: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_FENCE && flags_q.fence_to && todev_cnt != '0) |=>
        (!xfer_start && !sem_req && !db_we)); // R1

    AST_FENCE_FR_STALL: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_FENCE && flags_q.fence_fr && fromdev_cnt != '0) |=>
        (!xfer_start && !sem_req && !db_we)); // R2

    AST_SEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sem_req && !sem_grant) |=> sem_req); // R3

    AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start); // R7

    AST_DB_STRB: assert property (@(posedge clk) disable iff (rst)
        db_we |-> (db_strb == 4'b1111 || db_strb == 4'b0011 || db_strb == 4'b0001)); // R5

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (resp_push && resp_full) |=> (resp_push && $stable(resp_status))); // R8

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
        (resp_push || xfer_start || sem_req) |-> !req_ready); // R10

endmodule

// File: rtl/dreq_seq.sv
module dreq_seq
    import dreq_pkg::*;
#(
    parameter int NSEM = 2,
    parameter int SEMW = 8,
    parameter int DBAW = 16,
    parameter int CW   = 4,
    parameter int SIDW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [31:0]          req_ctrl,
    input  logic [SIDW-1:0]      req_seq_id,
    input  logic [NSEM-1:0]      req_sem_en,
    input  logic [NSEM-1:0]      req_sem_pre,
    input  logic [NSEM*SEMW-1:0] req_sem_id,
    input  logic [DBAW-1:0]      req_db_addr,
    input  logic [31:0]          req_db_data,
    input  logic [CW-1:0]        todev_cnt,
    input  logic [CW-1:0]        fromdev_cnt,
    output logic                 sem_req,
    output logic [SEMW-1:0]      sem_id,
    input  logic                 sem_grant,
    output logic                 xfer_start,
    input  logic                 xfer_done,
    output logic                 db_we,
    output logic [DBAW-1:0]      db_addr,
    output logic [31:0]          db_data,
    output logic [3:0]           db_strb,
    output logic                 resp_push,
    output logic [7:0]           resp_status,
    input  logic                 resp_full
);
    localparam int IW = (NSEM > 1) ? $clog2(NSEM) : 1;

    req_flags_t          flags_in;
    logic [NSEM-1:0]     pre_in, post_in, sel_mask;
    logic [NSEM*SEMW-1:0] ids_q;
    logic                pick_any;
    logic [IW-1:0]       pick_idx;
    logic                seq_unused;

    assign seq_unused = ^req_seq_id;

    dreq_decode #(.NSEM(NSEM)) u_decode (
        .ctrl      (req_ctrl),
        .sem_en    (req_sem_en),
        .sem_pre   (req_sem_pre),
        .flags     (flags_in),
        .pre_mask  (pre_in),
        .post_mask (post_in)
    );

    dreq_sem_pick #(.NSEM(NSEM), .SEMW(SEMW)) u_pick (
        .mask    (sel_mask),
        .id_flat (ids_q),
        .any     (pick_any),
        .idx     (pick_idx),
        .id      (sem_id)
    );

    dreq_ctrl #(.NSEM(NSEM), .SEMW(SEMW), .DBAW(DBAW), .CW(CW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .flags_in    (flags_in),
        .pre_in      (pre_in),
        .post_in     (post_in),
        .ids_in      (req_sem_id),
        .dba_in      (req_db_addr),
        .dbd_in      (req_db_data),
        .todev_cnt   (todev_cnt),
        .fromdev_cnt (fromdev_cnt),
        .sel_mask    (sel_mask),
        .ids_q       (ids_q),
        .pick_any    (pick_any),
        .pick_idx    (pick_idx),
        .sem_req     (sem_req),
        .sem_grant   (sem_grant),
        .xfer_start  (xfer_start),
        .xfer_done   (xfer_done),
        .db_we       (db_we),
        .db_addr     (db_addr),
        .db_data     (db_data),
        .db_strb     (db_strb),
        .resp_push   (resp_push),
        .resp_status (resp_status),
        .resp_full   (resp_full)
    );

endmodule

// File: tb/dreq_seq_bench.sv
module dreq_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_ctrl = '0;
    logic [15:0] req_seq_id = '0;
    logic [1:0]  req_sem_en = '0, req_sem_pre = '0;
    logic [15:0] req_sem_id = '0;
    logic [15:0] req_db_addr = '0;
    logic [31:0] req_db_data = '0;
    logic [3:0]  todev_cnt = '0, fromdev_cnt = '0;
    logic        sem_req, sem_grant, xfer_start, db_we, resp_push;
    logic        xfer_done = 1'b0, resp_full = 1'b0, sem_allow = 1'b1;
    logic [7:0]  sem_id, resp_status;
    logic [15:0] db_addr;
    logic [31:0] db_data;
    logic [3:0]  db_strb;

    int checks = 0, errors = 0, seen = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;
    assign sem_grant = sem_req && sem_allow;

    dreq_seq u_dreq_seq (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [63:0] ev, input string tag);
        exp_q.push_back(ev);
        tag_q.push_back(tag);
    endtask

    task automatic observe(input logic [63:0] ev);
        seen++;
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected event", ev, 64'h0);
        else begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(ev == e, t, ev, e);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (sem_req && sem_grant) observe({8'd1, 16'd0, sem_id, 32'd0});
            if (xfer_start)           observe({8'd2, 56'd0});
            if (db_we)                observe({8'd3, db_strb, 4'd0, db_addr, db_data});
            if (resp_push && !resp_full) observe({8'd4, 48'd0, resp_status});
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (xfer_start) begin
                repeat (3) @(posedge clk);
                #1 xfer_done = 1'b1;
                @(posedge clk);
                #1 xfer_done = 1'b0;
            end
        end
    end

    task automatic send(input logic [31:0] ctrl, input logic [1:0] en, input logic [1:0] pre,
                        input logic [7:0] id0, input logic [7:0] id1, input logic [15:0] addr,
                        input logic [31:0] data, input logic [15:0] sid, input string tag);
        logic [7:0] ids [2];
        logic [3:0] strb;
        logic [7:0] stat;
        bit multi;
        ids[0] = id0; ids[1] = id1;
        multi = (en[0] & pre[0]) && (en[1] & pre[1]);
        stat = 8'd0;
        if (multi) stat = 8'd2;
        else begin
            for (int i = 0; i < 2; i++) if (en[i] && pre[i]) expect_ev({8'd1, 16'd0, ids[i], 32'd0}, tag);
            if (ctrl[3]) expect_ev({8'd2, 56'd0}, tag);
            for (int i = 0; i < 2; i++) if (en[i] && !pre[i]) expect_ev({8'd1, 16'd0, ids[i], 32'd0}, tag);
            if (ctrl[2]) begin
                case (ctrl[1:0])
                    2'd0: strb = 4'b1111;
                    2'd1: strb = 4'b0011;
                    2'd2: strb = 4'b0001;
                    default: strb = 4'b0000;
                endcase
                if (ctrl[1:0] == 2'd3) stat = 8'd1;
                else expect_ev({8'd3, strb, 4'd0, addr, data}, tag);
            end
        end
        if (ctrl[4]) expect_ev({8'd4, 48'd0, stat}, tag);
        @(posedge clk); #1;
        req_ctrl = ctrl; req_sem_en = en; req_sem_pre = pre; req_sem_id = {id1, id0};
        req_db_addr = addr; req_db_data = data; req_seq_id = sid; req_valid = 1'b1;
        while (!req_ready) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while ((exp_q.size() != 0 || !req_ready) && n < 2000) begin @(posedge clk); n++; end
        check(exp_q.size() == 0 && req_ready, tag, 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(req_ready && !sem_req && !xfer_start && !db_we && !resp_push, "R10 reset state",
              {59'd0, req_ready, sem_req, xfer_start, db_we, resp_push}, 64'h10);

        // R3 R5 R8: full request, pre slot0 then xfer then post slot1, 32-bit doorbell
        send(32'h0000_001C, 2'b11, 2'b01, 8'h05, 8'h09, 16'h1234, 32'hCAFE_F00D, 16'h0001, "R3");
        drain("R3 full sequence");
        // R3: presync in slot 1, postsync in slot 0
        send(32'h0000_0018, 2'b11, 2'b10, 8'h21, 8'h42, 16'h0, 32'h0, 16'h0, "R3");
        drain("R3 slot order");
        // R5 R7: 16-bit and 8-bit doorbells without transfer
        send(32'h0000_0015, 2'b01, 2'b00, 8'h33, 8'h00, 16'hAA00, 32'h1111_2222, 16'h7, "R5");
        send(32'h0000_0016, 2'b00, 2'b00, 8'h00, 8'h00, 16'hBB00, 32'h3333_4444, 16'h8, "R7");
        drain("R5 R7 sizes");
        // R6: reserved length
        send(32'h0000_0017, 2'b00, 2'b00, 8'h00, 8'h00, 16'hCC00, 32'h5, 16'h9, "R6");
        drain("R6 reserved");
        // R4: two presyncs
        send(32'h0000_001C, 2'b11, 2'b11, 8'h01, 8'h02, 16'h1, 32'h1, 16'h0, "R4");
        drain("R4 multi presync");
        // R8: no completion flag, next request still served
        send(32'h0000_000C, 2'b00, 2'b00, 8'h00, 8'h00, 16'h0DB0, 32'h9, 16'h0, "R8");
        send(32'h0000_0010, 2'b00, 2'b00, 8'h00, 8'h00, 16'h0, 32'h0, 16'h0, "R8");
        drain("R8 no response");
        // R9: same request, different sequence IDs
        send(32'h0000_001C, 2'b01, 2'b00, 8'h77, 8'h00, 16'h4444, 32'h55, 16'h0000, "R9");
        send(32'h0000_001C, 2'b01, 2'b00, 8'h77, 8'h00, 16'h4444, 32'h55, 16'hFFFF, "R9");
        drain("R9 seq id ignored");

        // R1: to-device fence
        todev_cnt = 4'd3;
        base = seen;
        send(32'h4000_0018, 2'b00, 2'b00, 8'h00, 8'h00, 16'h0, 32'h0, 16'h0, "R1");
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(seen == base && !req_ready, "R1 fence stall", 64'(seen - base), 64'd0);
        todev_cnt = 4'd0;
        drain("R1 fence release");
        // R2: from-device fence, to-device count ignored
        fromdev_cnt = 4'd1;
        base = seen;
        send(32'h2000_0018, 2'b00, 2'b00, 8'h00, 8'h00, 16'h0, 32'h0, 16'h0, "R2");
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(seen == base && !req_ready, "R2 fence stall", 64'(seen - base), 64'd0);
        fromdev_cnt = 4'd0;
        drain("R2 fence release");

        // R3: semaphore held until granted
        sem_allow = 1'b0;
        base = seen;
        send(32'h0000_0018, 2'b01, 2'b01, 8'h66, 8'h00, 16'h0, 32'h0, 16'h0, "R3");
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(seen == base && sem_req && sem_id == 8'h66, "R3 presync wait",
              {55'd0, sem_req, sem_id}, {55'd0, 1'b1, 8'h66});
        sem_allow = 1'b1;
        drain("R3 presync grant");

        // R8 R10: response held while full, next request not accepted
        resp_full = 1'b1;
        base = seen;
        send(32'h0000_0010, 2'b00, 2'b00, 8'h00, 8'h00, 16'h0, 32'h0, 16'h0, "R8");
        fork
            send(32'h0000_0014, 2'b00, 2'b00, 8'h00, 8'h00, 16'hEEEE, 32'h77, 16'h0, "R10");
        join_none
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(seen == base && !req_ready && resp_push, "R10 busy while resp full",
              {62'd0, req_ready, resp_push}, 64'd1);
        resp_full = 1'b0;
        repeat (4) @(posedge clk);
        drain("R10 in-order after release");

        check(exp_q.size() == 0, "R10 scoreboard empty", 64'(exp_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule